// File: doc/BRIEF.md
# SDRAM Command Protocol Monitor

This block is a passive observer placed on the control side of a single-data-rate SDRAM interface. Every clock it samples clock enable, chip select, the three strobes, the bank select, the address bus and the two byte-mask pins. It drives nothing towards the memory. From these samples it follows the power-up sequence, keeps an open/closed bit for each bank and measures the spacing of refresh commands once the device is ready. When the controller breaks a rule, the monitor latches a 4-bit code that names the rule.

Power-up is accepted in this order. First comes a pause in which only idle commands appear. The first real command after the pause must be a precharge of all banks. Then come a mode-register load and eight auto refreshes, with the refreshes placed before or after the load. During normal operation the monitor flags these faults: column accesses to idle banks, activates to banks that are already open, refreshes issued while a row is open, and mode loads issued with a bank open or with clock enable low. A separate sticky flag reports a refresh that came too late.

Top module: `sdrmon_top`

## Requirements
- R1: Commands are decoded from {cs_n,ras_n,cas_n,we_n}: 0111 NOP, 0011 ACTIVE, 0101 READ, 0100 WRITE, 0110 BURST STOP, 0010 PRECHARGE, 0001 AUTO REFRESH, 0000 MODE SET. cs_n=1 is deselect. NOP and deselect count as idle.
- R2: The pause lasts PAUSE_CYCLES clocks after reset is released. A non-idle command during the pause latches code 1.
- R3: During the pause, cke low or any dqm bit low latches code 2.
- R4: After the pause, the first non-idle command must be PRECHARGE with addr[10]=1. Any other non-idle command latches code 3.
- R5: MODE SET issued after the pause latches code 4 in any of these cases: a bank is open, cke is low in that cycle, or cke was low in the cycle before.
- R6: init_done rises once all three have been seen: the precharge-all, one MODE SET and INIT_REFRESHES auto refreshes, with the refreshes before or after the MODE SET. init_done then stays high until reset.
- R7: A READ or WRITE to a bank with no open row latches code 5.
- R8: ACTIVE opens the addressed bank. ACTIVE to a bank that is already open latches code 6.
- R9: PRECHARGE closes every bank when addr[10]=1 and only the addressed bank when addr[10]=0. A READ or WRITE with addr[10]=1 closes its bank.
- R10: AUTO REFRESH while any bank is open latches code 7. With all banks closed it is legal.
- R11: ACTIVE after the precharge-all but before init_done latches code 8.
- R12: After reset err_flag and err_code are 0. A violation sets them on the clock edge that samples it. The first code is kept until reset. Violations in the same cycle resolve to the lowest code.
- R13: After init_done, REF_GAP consecutive cycles with no AUTO REFRESH raise ref_overdue on the edge that ends the last of them. The flag stays high until reset and does not alter err_code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cke | input | 1 | Observed clock enable |
| cs_n | input | 1 | Observed chip select |
| ras_n | input | 1 | Observed row strobe |
| cas_n | input | 1 | Observed column strobe |
| we_n | input | 1 | Observed write enable |
| ba | input | BA_BITS | Observed bank select |
| addr | input | ADDR_BITS | Observed address bus |
| dqm | input | DQM_BITS | Observed byte masks |
| init_done | output | 1 | Power-up sequence complete |
| err_flag | output | 1 | A rule was broken |
| err_code | output | 4 | Code of the first broken rule |
| ref_overdue | output | 1 | Refresh deadline missed |

## Verification
The main stimulus is a table. Each row resets the monitor and drives it to a chosen point: inside the pause, just after the pause, after the precharge-all, fully initialized, or initialized with bank 1 open. It then issues one command and compares the latched code. This separates rules that share a command but depend on phase, such as an ACTIVE answered with code 1, 3, 8, 6 or 0 depending on where it lands. Directed runs then cover the corners: the two refresh/mode-set orderings, auto-precharge closing only its own bank, a single-bank precharge leaving other rows open, a second fault not replacing the first, and a refresh arriving exactly at the deadline against one arriving a cycle late.

// File: rtl/sdrmon_pkg.sv
// Shared types of the SDRAM command monitor: decoded command set,
// power-up phase and the error codes reported at the top level.
package sdrmon_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL = 4'd0,
        CMD_NOP   = 4'd1,
        CMD_ACT   = 4'd2,
        CMD_RD    = 4'd3,
        CMD_WR    = 4'd4,
        CMD_BST   = 4'd5,
        CMD_PRE   = 4'd6,
        CMD_REF   = 4'd7,
        CMD_MRS   = 4'd8
    } cmd_e;

    typedef enum logic [1:0] {
        PH_PAUSE    = 2'd0,
        PH_WAIT_PRE = 2'd1,
        PH_SETUP    = 2'd2,
        PH_READY    = 2'd3
    } phase_e;

    // Lower value wins when several rules fail in one cycle.
    typedef enum logic [3:0] {
        ERR_NONE      = 4'd0,
        ERR_PAUSE_CMD = 4'd1,
        ERR_PAUSE_PIN = 4'd2,
        ERR_FIRST_CMD = 4'd3,
        ERR_MODE_SET  = 4'd4,
        ERR_RW_IDLE   = 4'd5,
        ERR_ACT_OPEN  = 4'd6,
        ERR_REF_OPEN  = 4'd7,
        ERR_EARLY_ACT = 4'd8
    } err_e;

endpackage

// File: rtl/sdrmon_decode.sv
// Command decoder.
// Turns the chip-select and strobe pins into one command value.
// Assumes the pins are sampled on the same edge as everything else;
// clock enable is judged by the phase tracker, not here.
module sdrmon_decode
    import sdrmon_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    // Purpose: map {ras_n,cas_n,we_n} to a command when selected.
    always_comb begin
        if (cs_n) begin
            cmd = CMD_DESEL;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  cmd = CMD_NOP;
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = CMD_RD;
                3'b100:  cmd = CMD_WR;
                3'b110:  cmd = CMD_BST;
                3'b010:  cmd = CMD_PRE;
                3'b001:  cmd = CMD_REF;
                default: cmd = CMD_MRS;
            endcase
        end
    end

endmodule

// File: rtl/sdrmon_init.sv
// Power-up phase tracker.
// Follows the pause, the precharge-all, the refresh count and the
// mode load, and reports the phase-dependent rule violations.
// Assumes all_closed reflects bank state before the current command.
module sdrmon_init
    import sdrmon_pkg::*;
#(
    parameter int PAUSE_CYCLES   = 20000,
    parameter int INIT_REFRESHES = 8,
    parameter int DQM_BITS       = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  cmd_e                cmd,
    input  logic                a10,
    input  logic                cke,
    input  logic [DQM_BITS-1:0] dqm,
    input  logic                all_closed,
    output logic                init_done,
    output logic                e_pause_cmd,
    output logic                e_pause_pin,
    output logic                e_first_cmd,
    output logic                e_mode_set,
    output logic                e_early_act
);

    localparam int PW = $clog2(PAUSE_CYCLES + 1);
    localparam int RW = $clog2(INIT_REFRESHES + 1);
    localparam logic [PW-1:0] PAUSE_LAST = PW'(PAUSE_CYCLES - 1);
    localparam logic [RW-1:0] REF_TARGET = RW'(INIT_REFRESHES);

    phase_e        phase_q;
    logic [PW-1:0] pause_cnt_q;
    logic [RW-1:0] ref_cnt_q, ref_cnt_d;
    logic          mrs_seen_q, mrs_seen_d;
    logic          cke_q;
    logic          busy_cmd;
    logic          pre_all;

    assign busy_cmd  = (cmd != CMD_DESEL) && (cmd != CMD_NOP);
    assign pre_all   = (cmd == CMD_PRE) && a10;
    assign init_done = (phase_q == PH_READY);

    // Purpose: flag each phase rule broken by the current sample.
    always_comb begin
        e_pause_cmd = (phase_q == PH_PAUSE) && busy_cmd;
        e_pause_pin = (phase_q == PH_PAUSE) && (!cke || (dqm != '1));
        e_first_cmd = (phase_q == PH_WAIT_PRE) && busy_cmd && !pre_all;
        e_mode_set  = ((phase_q == PH_SETUP) || (phase_q == PH_READY)) &&
                      (cmd == CMD_MRS) && (!all_closed || !cke || !cke_q);
        e_early_act = (phase_q == PH_SETUP) && (cmd == CMD_ACT);
    end

    // Purpose: next values of the refresh count and mode-load marker.
    always_comb begin
        ref_cnt_d  = ref_cnt_q;
        mrs_seen_d = mrs_seen_q;
        if (phase_q == PH_SETUP) begin
            if ((cmd == CMD_REF) && (ref_cnt_q != REF_TARGET)) begin
                ref_cnt_d = ref_cnt_q + 1'b1;
            end
            if (cmd == CMD_MRS) begin
                mrs_seen_d = 1'b1;
            end
        end
    end

    // Purpose: remember clock enable of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke_q <= 1'b0;
        end else begin
            cke_q <= cke;
        end
    end

    // Purpose: advance the power-up phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_PAUSE;
            pause_cnt_q <= '0;
            ref_cnt_q   <= '0;
            mrs_seen_q  <= 1'b0;
        end else begin
            case (phase_q)
                PH_PAUSE: begin
                    if (pause_cnt_q == PAUSE_LAST) begin
                        phase_q <= PH_WAIT_PRE;
                    end else begin
                        pause_cnt_q <= pause_cnt_q + 1'b1;
                    end
                end
                PH_WAIT_PRE: begin
                    if (pre_all) begin
                        phase_q <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    ref_cnt_q  <= ref_cnt_d;
                    mrs_seen_q <= mrs_seen_d;
                    if ((ref_cnt_d == REF_TARGET) && mrs_seen_d) begin
                        phase_q <= PH_READY;
                    end
                end
                default: phase_q <= PH_READY;
            endcase
        end
    end

    // R6: once ready, the monitor stays ready.
    p_done_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R6: readiness needs a mode load seen now or earlier.
    p_done_needs_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> ($past(mrs_seen_q) || $past(cmd == CMD_MRS)));

    // R2: the pause counter never passes its last value.
    p_pause_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_PAUSE) |-> (pause_cnt_q <= PAUSE_LAST));

endmodule

// File: rtl/sdrmon_banks.sv
// Per-bank row tracker.
// Keeps one open bit per bank from ACTIVE, PRECHARGE and
// auto-precharge column commands, and reports bank-state violations.
// Assumes the ACTIVE and column commands carry a valid bank select.
module sdrmon_banks
    import sdrmon_pkg::*;
#(
    parameter int BA_BITS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  cmd_e               cmd,
    input  logic [BA_BITS-1:0] ba,
    input  logic               a10,
    output logic               all_closed,
    output logic               e_rw_idle,
    output logic               e_act_open,
    output logic               e_ref_open
);

    localparam int NUM_BANKS = 1 << BA_BITS;

    logic [NUM_BANKS-1:0] bank_open;
    logic                 col_cmd;

    assign col_cmd = (cmd == CMD_RD) || (cmd == CMD_WR);

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        localparam logic [BA_BITS-1:0] IDX = BA_BITS'(g);
        logic open_q;

        // Purpose: set or clear this bank's open bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q <= 1'b0;
            end else if ((cmd == CMD_ACT) && (ba == IDX)) begin
                open_q <= 1'b1;
            end else if ((cmd == CMD_PRE) && (a10 || (ba == IDX))) begin
                open_q <= 1'b0;
            end else if (col_cmd && a10 && (ba == IDX)) begin
                open_q <= 1'b0;
            end
        end

        assign bank_open[g] = open_q;
    end

    // Purpose: report state rules against the bank bits before update.
    always_comb begin
        all_closed = (bank_open == '0);
        e_rw_idle  = col_cmd && !bank_open[ba];
        e_act_open = (cmd == CMD_ACT) && bank_open[ba];
        e_ref_open = (cmd == CMD_REF) && !all_closed;
    end

    // R8: an activate leaves its bank open.
    p_act_opens_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT) |=> bank_open[$past(ba)]);

    // R9: a column command with auto-precharge closes its bank.
    p_auto_pre_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (col_cmd && a10) |=> !bank_open[$past(ba)]);

    // R9: precharge-all leaves every bank closed.
    p_pre_all_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == CMD_PRE) && a10) |=> (bank_open == '0));

endmodule

// File: rtl/sdrmon_refresh.sv
// Refresh deadline watcher.
// Counts cycles since the last AUTO REFRESH once power-up is done and
// raises a sticky flag when REF_GAP cycles pass without one.
// Assumes REF_GAP is at least 2.
module sdrmon_refresh
    import sdrmon_pkg::*;
#(
    parameter int REF_GAP = 780
) (
    input  logic clk,
    input  logic rst_n,
    input  cmd_e cmd,
    input  logic init_done,
    output logic ref_overdue
);

    localparam int GW = $clog2(REF_GAP + 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(REF_GAP - 1);

    logic [GW-1:0] gap_q;
    logic          late_q;

    assign ref_overdue = late_q;

    // Purpose: measure the refresh gap and latch a missed deadline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            late_q <= 1'b0;
        end else if (!init_done || (cmd == CMD_REF)) begin
            gap_q <= '0;
        end else if (gap_q == GAP_LAST) begin
            late_q <= 1'b1;
        end else begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R13: the overdue flag is sticky.
    p_overdue_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        ref_overdue |=> ref_overdue);

    // R13: the flag cannot rise before the monitor is ready.
    p_overdue_after_init_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_overdue) |-> $past(init_done));

    // R13: the gap counter stays within its window.
    p_gap_bound_r13: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= GAP_LAST);

endmodule

// File: rtl/sdrmon_top.sv
// SDRAM command protocol monitor, top level.
// Decodes the observed bus, feeds the phase tracker, the bank tracker
// and the refresh watcher, and latches the first rule violation.
// Assumes it only observes; it drives nothing on the memory bus.
module sdrmon_top
    import sdrmon_pkg::*;
#(
    parameter int PAUSE_CYCLES   = 20000,
    parameter int INIT_REFRESHES = 8,
    parameter int REF_GAP        = 780,
    parameter int BA_BITS        = 2,
    parameter int ADDR_BITS      = 13,
    parameter int AP_BIT         = 10,
    parameter int DQM_BITS       = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cke,
    input  logic                 cs_n,
    input  logic                 ras_n,
    input  logic                 cas_n,
    input  logic                 we_n,
    input  logic [BA_BITS-1:0]   ba,
    input  logic [ADDR_BITS-1:0] addr,
    input  logic [DQM_BITS-1:0]  dqm,
    output logic                 init_done,
    output logic                 err_flag,
    output logic [3:0]           err_code,
    output logic                 ref_overdue
);

    cmd_e cmd;
    logic a10;
    logic all_closed;
    logic e_pause_cmd, e_pause_pin, e_first_cmd, e_mode_set, e_early_act;
    logic e_rw_idle, e_act_open, e_ref_open;
    err_e new_err;
    err_e code_q;
    logic unused_addr_bits;

    assign a10              = addr[AP_BIT];
    assign unused_addr_bits = ^addr;

    sdrmon_decode u_decode (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    sdrmon_init #(
        .PAUSE_CYCLES   (PAUSE_CYCLES),
        .INIT_REFRESHES (INIT_REFRESHES),
        .DQM_BITS       (DQM_BITS)
    ) u_init (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd         (cmd),
        .a10         (a10),
        .cke         (cke),
        .dqm         (dqm),
        .all_closed  (all_closed),
        .init_done   (init_done),
        .e_pause_cmd (e_pause_cmd),
        .e_pause_pin (e_pause_pin),
        .e_first_cmd (e_first_cmd),
        .e_mode_set  (e_mode_set),
        .e_early_act (e_early_act)
    );

    sdrmon_banks #(
        .BA_BITS (BA_BITS)
    ) u_banks (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .ba         (ba),
        .a10        (a10),
        .all_closed (all_closed),
        .e_rw_idle  (e_rw_idle),
        .e_act_open (e_act_open),
        .e_ref_open (e_ref_open)
    );

    sdrmon_refresh #(
        .REF_GAP (REF_GAP)
    ) u_refresh (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd         (cmd),
        .init_done   (init_done),
        .ref_overdue (ref_overdue)
    );

    // Purpose: pick the lowest-numbered violation of this cycle.
    always_comb begin
        if      (e_pause_cmd) new_err = ERR_PAUSE_CMD;
        else if (e_pause_pin) new_err = ERR_PAUSE_PIN;
        else if (e_first_cmd) new_err = ERR_FIRST_CMD;
        else if (e_mode_set)  new_err = ERR_MODE_SET;
        else if (e_rw_idle)   new_err = ERR_RW_IDLE;
        else if (e_act_open)  new_err = ERR_ACT_OPEN;
        else if (e_ref_open)  new_err = ERR_REF_OPEN;
        else if (e_early_act) new_err = ERR_EARLY_ACT;
        else                  new_err = ERR_NONE;
    end

    // Purpose: hold the first violation until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= ERR_NONE;
        end else if (code_q == ERR_NONE) begin
            code_q <= new_err;
        end
    end

    assign err_code = code_q;
    assign err_flag = (code_q != ERR_NONE);

    // R12: a latched code never changes before reset.
    p_first_err_kept_r12: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> $stable(err_code));

    // R12: a violation always leaves a nonzero code behind.
    p_err_latched_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (new_err != ERR_NONE) |=> err_flag);

    // R2: no rule of the ready phase fires during the pause.
    p_pause_isolated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        e_pause_cmd |-> !e_first_cmd && !e_mode_set && !e_early_act);

endmodule

// File: tb/sdrmon_top_test.sv
`timescale 1ns/1ps
module sdrmon_top_test;

    localparam int PAUSE = 30;
    localparam int GAP   = 40;

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_REF = 4'b0001;
    localparam logic [3:0] C_MRS = 4'b0000;

    // {stage[20:18], req[17:14], cmd[13:10], ba[9:8], a10[7], cke[6], dqm[5:4], expected code[3:0]}
    // stage: 0 in pause, 1 after pause, 2 after precharge-all, 3 ready, 4 ready with bank 1 open
    localparam int NV = 17;
    localparam logic [20:0] VEC [NV] = '{
        {3'd0, 4'd2,  C_ACT, 2'd0, 1'b0, 1'b1, 2'b11, 4'd1}, // R2
        {3'd0, 4'd3,  C_NOP, 2'd0, 1'b0, 1'b0, 2'b11, 4'd2}, // R3 cke low
        {3'd0, 4'd3,  C_NOP, 2'd0, 1'b0, 1'b1, 2'b01, 4'd2}, // R3 mask low
        {3'd1, 4'd4,  C_ACT, 2'd0, 1'b0, 1'b1, 2'b11, 4'd3}, // R4
        {3'd1, 4'd4,  C_PRE, 2'd0, 1'b0, 1'b1, 2'b11, 4'd3}, // R4 single-bank
        {3'd1, 4'd4,  C_PRE, 2'd0, 1'b1, 1'b1, 2'b11, 4'd0}, // R4 legal
        {3'd1, 4'd4,  C_MRS, 2'd0, 1'b0, 1'b1, 2'b11, 4'd3}, // R4
        {3'd2, 4'd10, C_REF, 2'd0, 1'b0, 1'b1, 2'b11, 4'd0}, // R10 closed ok
        {3'd4, 4'd5,  C_MRS, 2'd0, 1'b0, 1'b1, 2'b11, 4'd4}, // R5 bank open
        {3'd3, 4'd5,  C_MRS, 2'd0, 1'b0, 1'b1, 2'b11, 4'd0}, // R5 legal
        {3'd3, 4'd7,  C_RD,  2'd2, 1'b0, 1'b1, 2'b11, 4'd5}, // R7
        {3'd3, 4'd7,  C_WR,  2'd0, 1'b0, 1'b1, 2'b11, 4'd5}, // R7
        {3'd4, 4'd8,  C_ACT, 2'd1, 1'b0, 1'b1, 2'b11, 4'd6}, // R8
        {3'd4, 4'd8,  C_ACT, 2'd3, 1'b0, 1'b1, 2'b11, 4'd0}, // R8 other bank
        {3'd4, 4'd10, C_REF, 2'd0, 1'b0, 1'b1, 2'b11, 4'd7}, // R10
        {3'd2, 4'd11, C_ACT, 2'd0, 1'b0, 1'b1, 2'b11, 4'd8}, // R11
        {3'd4, 4'd9,  C_RD,  2'd1, 1'b0, 1'b1, 2'b11, 4'd0}  // R9 open read, R1 decode
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cke, cs_n, ras_n, cas_n, we_n;
    logic [1:0]  ba;
    logic [12:0] addr;
    logic [1:0]  dqm;
    logic        init_done, err_flag, ref_overdue;
    logic [3:0]  err_code;
    int          checks = 0;
    int          fails  = 0;

    always #2 clk = ~clk;

    sdrmon_top #(
        .PAUSE_CYCLES (PAUSE),
        .REF_GAP      (GAP)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cke         (cke),
        .cs_n        (cs_n),
        .ras_n       (ras_n),
        .cas_n       (cas_n),
        .we_n        (we_n),
        .ba          (ba),
        .addr        (addr),
        .dqm         (dqm),
        .init_done   (init_done),
        .err_flag    (err_flag),
        .err_code    (err_code),
        .ref_overdue (ref_overdue)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive one bus cycle at the falling edge; returns after the next one.
    task automatic issue(input logic [3:0] c, input logic [1:0] b, input logic a,
                         input logic k, input logic [1:0] d);
        {cs_n, ras_n, cas_n, we_n} = c;
        ba   = b;
        addr = 13'h005 | (13'(a) << 10);
        cke  = k;
        dqm  = d;
        @(negedge clk);
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) issue(C_NOP, 2'd0, 1'b0, 1'b1, 2'b11);
    endtask

    task automatic reset_dut();
        rst_n = 1'b0;
        nop(2);
        rst_n = 1'b1;
    endtask

    task automatic full_init(input bit ref_first);
        nop(PAUSE);
        issue(C_PRE, 2'd0, 1'b1, 1'b1, 2'b11);
        nop(1);
        if (ref_first) begin
            for (int i = 0; i < 8; i++) begin
                issue(C_REF, 2'd0, 1'b0, 1'b1, 2'b11);
                nop(1);
            end
            issue(C_MRS, 2'd0, 1'b0, 1'b1, 2'b11);
            nop(2);
        end else begin
            issue(C_MRS, 2'd0, 1'b0, 1'b1, 2'b11);
            nop(1);
            for (int i = 0; i < 8; i++) begin
                issue(C_REF, 2'd0, 1'b0, 1'b1, 2'b11);
                nop(1);
            end
        end
    endtask

    task automatic goto_stage(input int s);
        reset_dut();
        case (s)
            0: nop(3);
            1: nop(PAUSE);
            2: begin
                nop(PAUSE);
                issue(C_PRE, 2'd0, 1'b1, 1'b1, 2'b11);
                nop(1);
            end
            3: full_init(1'b1);
            default: begin
                full_init(1'b1);
                issue(C_ACT, 2'd1, 1'b0, 1'b1, 2'b11);
                nop(1);
            end
        endcase
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R12 watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        {cs_n, ras_n, cas_n, we_n} = C_NOP;
        ba = '0; addr = '0; cke = 1'b1; dqm = 2'b11;
        @(negedge clk);

        // Reset state (R12, R6, R13)
        reset_dut();
        chk("R12 reset err_flag", int'(err_flag), 0);
        chk("R12 reset err_code", int'(err_code), 0);
        chk("R6 reset init_done", int'(init_done), 0);
        chk("R13 reset ref_overdue", int'(ref_overdue), 0);

        // Table walk
        for (int v = 0; v < NV; v++) begin
            goto_stage(int'(VEC[v][20:18]));
            issue(VEC[v][13:10], VEC[v][9:8], VEC[v][7], VEC[v][6], VEC[v][5:4]);
            nop(1);
            chk($sformatf("R%0d vector %0d", VEC[v][17:14], v),
                int'(err_code), int'(VEC[v][3:0]));
        end

        // R6: refreshes before the mode load
        reset_dut();
        full_init(1'b1);
        chk("R6 refresh-first init_done", int'(init_done), 1);
        chk("R6 refresh-first err_code", int'(err_code), 0);

        // R6: mode load first, readiness only after the eighth refresh
        reset_dut();
        nop(PAUSE);
        issue(C_PRE, 2'd0, 1'b1, 1'b1, 2'b11);
        issue(C_MRS, 2'd0, 1'b0, 1'b1, 2'b11);
        for (int i = 0; i < 7; i++) issue(C_REF, 2'd0, 1'b0, 1'b1, 2'b11);
        chk("R6 seven refreshes init_done", int'(init_done), 0);
        issue(C_REF, 2'd0, 1'b0, 1'b1, 2'b11);
        chk("R6 eighth refresh init_done", int'(init_done), 1);
        nop(2);
        chk("R6 mode-first err_code", int'(err_code), 0);

        // R5: clock enable low in the cycle before the mode load
        reset_dut();
        nop(PAUSE);
        issue(C_PRE, 2'd0, 1'b1, 1'b1, 2'b11);
        issue(C_NOP, 2'd0, 1'b0, 1'b0, 2'b11);
        issue(C_MRS, 2'd0, 1'b0, 1'b1, 2'b11);
        nop(1);
        chk("R5 cke low before mode load", int'(err_code), 4);

        // R9: auto-precharge write closes its bank
        reset_dut();
        full_init(1'b0);
        issue(C_ACT, 2'd1, 1'b0, 1'b1, 2'b11);
        issue(C_WR,  2'd1, 1'b1, 1'b1, 2'b11);
        nop(1);
        chk("R9 auto-precharge write legal", int'(err_code), 0);
        issue(C_RD,  2'd1, 1'b0, 1'b1, 2'b11);
        nop(1);
        chk("R9 read after auto-precharge", int'(err_code), 5);

        // R9: single-bank precharge leaves the other bank open
        reset_dut();
        full_init(1'b1);
        issue(C_ACT, 2'd0, 1'b0, 1'b1, 2'b11);
        issue(C_ACT, 2'd1, 1'b0, 1'b1, 2'b11);
        issue(C_PRE, 2'd0, 1'b0, 1'b1, 2'b11);
        issue(C_RD,  2'd1, 1'b0, 1'b1, 2'b11);
        nop(1);
        chk("R9 other bank still open", int'(err_code), 0);
        issue(C_RD,  2'd0, 1'b0, 1'b1, 2'b11);
        nop(1);
        chk("R9 precharged bank closed", int'(err_code), 5);

        // R9, R10: precharge-all then refresh is legal
        reset_dut();
        full_init(1'b1);
        issue(C_ACT, 2'd2, 1'b0, 1'b1, 2'b11);
        issue(C_ACT, 2'd3, 1'b0, 1'b1, 2'b11);
        issue(C_PRE, 2'd0, 1'b1, 1'b1, 2'b11);
        issue(C_REF, 2'd0, 1'b0, 1'b1, 2'b11);
        nop(1);
        chk("R10 refresh after precharge-all", int'(err_code), 0);

        // R12: first code kept over a later one
        reset_dut();
        full_init(1'b1);
        issue(C_ACT, 2'd1, 1'b0, 1'b1, 2'b11);
        chk("R12 no error yet", int'(err_flag), 0);
        issue(C_ACT, 2'd1, 1'b0, 1'b1, 2'b11);
        chk("R12 flag on next edge", int'(err_flag), 1);
        issue(C_RD,  2'd3, 1'b0, 1'b1, 2'b11);
        nop(2);
        chk("R12 first code kept", int'(err_code), 6);

        // R12: same-cycle violations resolve to the lowest code
        reset_dut();
        nop(2);
        issue(C_ACT, 2'd0, 1'b0, 1'b0, 2'b00);
        nop(1);
        chk("R12 priority in pause", int'(err_code), 1);

        // R13: refresh exactly at the deadline, then one cycle late
        reset_dut();
        full_init(1'b1);
        issue(C_REF, 2'd0, 1'b0, 1'b1, 2'b11);
        nop(GAP - 1);
        issue(C_REF, 2'd0, 1'b0, 1'b1, 2'b11);
        chk("R13 refresh on time", int'(ref_overdue), 0);
        nop(GAP - 1);
        chk("R13 one cycle before deadline", int'(ref_overdue), 0);
        nop(1);
        chk("R13 deadline missed", int'(ref_overdue), 1);
        nop(3);
        chk("R13 flag sticky", int'(ref_overdue), 1);
        chk("R13 err_code untouched", int'(err_code), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule